// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the single-root I/O virtualization capability registers of a PCIe physical function. Software reaches it through a dword configuration port with a read strobe, a write strobe, a dword address and four byte enables. The capability occupies a window of `CAP_DW` dwords starting at dword address `CAP_BASE`. Inside that window the block keeps the control bits, the requested VF count and the selected system page size. It also presents the read-only values: initial and total VF counts, first-VF routing offset and stride, VF device ID and the supported page-size mask.

Besides being a register file, the block tracks whether virtual functions are actually brought up. Setting the enable bit starts the VFs only if the requested count fits within the total. Clearing the enable bit tears all of them down. The resulting active flag and active VF count are exported for the function-allocation logic elsewhere in the chip. The total VF count and optional page sizes come in as strap inputs. The other identity values are parameters.

Top module: `sriov_cap_regs`

## Requirements
- R1: After reset the control dword, requested count and active count read zero, `vf_enabled` is low, and the system page size reads 0x0001.
- R2: In the control dword (window offset 1, bits 15:0), only bit 0 (VF enable), bit 3 (VF memory enable) and bit 4 (ARI hierarchy) can be written. Every other bit of the dword, including bits 31:16, reads zero.
- R3: The requested VF count (offset 3, bits 15:0) is writable in all 16 bits, and bits 31:16 read zero.
- R4: These fields read back their strap or parameter values and ignore writes: initial count (offset 2, bits 15:0), total count (offset 2, bits 31:16), routing offset (offset 4, bits 15:0), stride (offset 4, bits 31:16) and VF device ID (offset 5, bits 31:16).
- R5: Supported page sizes (offset 6, bits 15:0) read as 0x0553 OR `opt_pgsz`, and ignore writes.
- R6: In the system page size (offset 7, bits 15:0), a bit is writable exactly when it is set in the supported mask. All other bits keep their value.
- R7: A control write with bit 0 set while no VFs are active, and with the requested count at most `total_vfs`, raises `vf_enabled` and loads `vf_active_cnt` with the requested count. Both change at the clock edge that takes the write.
- R8: A control write with bit 0 set while inactive, but with the requested count above `total_vfs`, activates nothing. The stored enable bit still reads back 1.
- R9: While active, a control write with bit 0 clear drops `vf_enabled` and zeroes the active count on the same edge. A control write with bit 0 set leaves the active count unchanged, even if the requested count has changed since activation.
- R10: Activation and deactivation happen only for writes to the control dword whose byte enable 0 is set.
- R11: Writes outside the window change nothing, and reads outside it return zero. Unmapped dwords inside the window read zero.
- R12: Byte enables act per byte. A byte whose enable is clear keeps its old value whatever the write mask allows.
- R13: Read data appears on `cfg_rdata` one clock after `cfg_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Dword address |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| total_vfs | input | 16 | Strapped total VF count |
| opt_pgsz | input | 16 | Optional page sizes added to the mandatory set |
| vf_enabled | output | 1 | VFs are currently active |
| vf_active_cnt | output | 16 | Number of active VFs |

## Verification
The bench targets the edge where the requested count equals the total and the count one above it. A design that compares the wrong way either refuses a legal request or activates VFs it cannot back. It rewrites the requested count and sets enable again while VFs are up; a design that re-samples the count would move the active count. Control writes without byte enable 0 are sent, and so are writes just outside the window. A design that ignores the byte range or aliases the address would toggle VFs on those. It also writes the system page size before and after optional sizes are added, which catches a fixed write mask that ignores the supported set.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;
    // window offsets (dwords); the control offset drives enable processing
    localparam int unsigned OFS_CTRL   = 1;
    localparam int unsigned OFS_COUNTS = 2;
    localparam int unsigned OFS_NUMVF  = 3;
    localparam int unsigned OFS_ROUTE  = 4;
    localparam int unsigned OFS_DEVID  = 5;
    localparam int unsigned OFS_SUPPG  = 6;
    localparam int unsigned OFS_SYSPG  = 7;

    localparam int unsigned BIT_VFE = 0;
    localparam int unsigned BIT_MSE = 3;
    localparam int unsigned BIT_ARI = 4;

    localparam int unsigned FW = 16;   // field width
    localparam int unsigned DW = 32;   // port data width

    localparam logic [FW-1:0] CTRL_WMASK = (FW'(1) << BIT_VFE) | (FW'(1) << BIT_MSE)
                                         | (FW'(1) << BIT_ARI);
    localparam logic [FW-1:0] PG_MIN     = 16'h0553;
    localparam logic [FW-1:0] PG_RESET   = 16'h0001;

    typedef struct packed {
        logic [FW-1:0] ctrl;
        logic [FW-1:0] num_vf;
        logic [FW-1:0] sys_pg;
        logic          active;
        logic [FW-1:0] act_cnt;
        logic [DW-1:0] rdata;
    } regs_t;
endpackage

// File: rtl/sriov_byte_merge.sv
module sriov_byte_merge #(
    parameter int unsigned NBYTES = 4
) (
    input  logic [8*NBYTES-1:0] old_val,
    input  logic [8*NBYTES-1:0] new_val,
    input  logic [8*NBYTES-1:0] wmask,
    input  logic [NBYTES-1:0]   be,
    output logic [8*NBYTES-1:0] merged
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign merged[8*b +: 8] = be[b]
            ? ((old_val[8*b +: 8] & ~wmask[8*b +: 8]) | (new_val[8*b +: 8] & wmask[8*b +: 8]))
            : old_val[8*b +: 8];
    end
endmodule

// File: rtl/sriov_vf_ctl.sv
module sriov_vf_ctl
    import sriov_cap_pkg::*;
(
    input  logic          ctrl_wr,
    input  logic          vfe_bit,
    input  logic          active_q,
    input  logic [FW-1:0] cnt_q,
    input  logic [FW-1:0] num_vf_q,
    input  logic [FW-1:0] total_vfs,
    output logic          active_d,
    output logic [FW-1:0] cnt_d
);
    always_comb begin
        active_d = active_q;
        cnt_d    = cnt_q;
        if (ctrl_wr) begin
            if (active_q) begin
                if (!vfe_bit) begin
                    active_d = 1'b0;
                    cnt_d    = '0;
                end
            end else if (vfe_bit && (num_vf_q <= total_vfs)) begin
                active_d = 1'b1;
                cnt_d    = num_vf_q;
            end
        end
    end
endmodule

// File: rtl/sriov_rd_mux.sv
module sriov_rd_mux
    import sriov_cap_pkg::*;
#(
    parameter int unsigned OFS_W = 4
) (
    input  logic             in_win,
    input  logic [OFS_W-1:0] ofs,
    input  logic [FW-1:0]    ctrl,
    input  logic [FW-1:0]    init_vfs,
    input  logic [FW-1:0]    total_vfs,
    input  logic [FW-1:0]    num_vf,
    input  logic [FW-1:0]    route_ofs,
    input  logic [FW-1:0]    route_stride,
    input  logic [FW-1:0]    dev_id,
    input  logic [FW-1:0]    sup_pg,
    input  logic [FW-1:0]    sys_pg,
    output logic [DW-1:0]    data
);
    always_comb begin
        data = '0;
        if (in_win) begin
            unique case (int'(ofs))
                OFS_CTRL:   data = {16'h0, ctrl};
                OFS_COUNTS: data = {total_vfs, init_vfs};
                OFS_NUMVF:  data = {16'h0, num_vf};
                OFS_ROUTE:  data = {route_stride, route_ofs};
                OFS_DEVID:  data = {dev_id, 16'h0};
                OFS_SUPPG:  data = {16'h0, sup_pg};
                OFS_SYSPG:  data = {16'h0, sys_pg};
                default:    data = '0;
            endcase
        end
    end
endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
    import sriov_cap_pkg::*;
#(
    parameter int unsigned   ADDR_W    = 10,
    parameter int unsigned   CAP_BASE  = 64,
    parameter int unsigned   CAP_DW    = 16,
    parameter logic [15:0]   INIT_VFS  = 16'd4,
    parameter logic [15:0]   VF_OFFSET = 16'd1,
    parameter logic [15:0]   VF_STRIDE = 16'd2,
    parameter logic [15:0]   VF_DEVID  = 16'h1235
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [15:0]       total_vfs,
    input  logic [15:0]       opt_pgsz,
    output logic              vf_enabled,
    output logic [15:0]       vf_active_cnt
);
    localparam int unsigned OFS_W = $clog2(CAP_DW);
    localparam int unsigned NBYTE = DW / 8;

    regs_t r_q, r_d;

    // window decode
    logic [ADDR_W:0]  rel;
    logic             in_win;
    logic [OFS_W-1:0] ofs;
    assign rel    = {1'b0, cfg_addr} - (ADDR_W+1)'(CAP_BASE);
    assign in_win = !rel[ADDR_W] && (rel < (ADDR_W+1)'(CAP_DW));
    assign ofs    = rel[OFS_W-1:0];

    logic wr_ctrl, wr_numvf, wr_syspg;
    assign wr_ctrl  = cfg_wr && in_win && (ofs == OFS_W'(OFS_CTRL));
    assign wr_numvf = cfg_wr && in_win && (ofs == OFS_W'(OFS_NUMVF));
    assign wr_syspg = cfg_wr && in_win && (ofs == OFS_W'(OFS_SYSPG));

    logic [FW-1:0] sup_pg;
    assign sup_pg = PG_MIN | opt_pgsz;

    logic [DW-1:0] ctrl_m, numvf_m, syspg_m;

    sriov_byte_merge #(.NBYTES(NBYTE)) u_merge_ctrl (
        .old_val ({16'h0, r_q.ctrl}),
        .new_val (cfg_wdata),
        .wmask   ({16'h0, CTRL_WMASK}),
        .be      (cfg_be),
        .merged  (ctrl_m)
    );

    sriov_byte_merge #(.NBYTES(NBYTE)) u_merge_numvf (
        .old_val ({16'h0, r_q.num_vf}),
        .new_val (cfg_wdata),
        .wmask   ({16'h0, 16'hFFFF}),
        .be      (cfg_be),
        .merged  (numvf_m)
    );

    sriov_byte_merge #(.NBYTES(NBYTE)) u_merge_syspg (
        .old_val ({16'h0, r_q.sys_pg}),
        .new_val (cfg_wdata),
        .wmask   ({16'h0, sup_pg}),
        .be      (cfg_be),
        .merged  (syspg_m)
    );

    logic          act_d;
    logic [FW-1:0] cnt_d;

    sriov_vf_ctl u_vf_ctl (
        .ctrl_wr   (wr_ctrl && cfg_be[0]),
        .vfe_bit   (cfg_wdata[BIT_VFE]),
        .active_q  (r_q.active),
        .cnt_q     (r_q.act_cnt),
        .num_vf_q  (r_q.num_vf),
        .total_vfs (total_vfs),
        .active_d  (act_d),
        .cnt_d     (cnt_d)
    );

    logic [DW-1:0] rd_val;

    sriov_rd_mux #(.OFS_W(OFS_W)) u_rd_mux (
        .in_win       (in_win),
        .ofs          (ofs),
        .ctrl         (r_q.ctrl),
        .init_vfs     (INIT_VFS),
        .total_vfs    (total_vfs),
        .num_vf       (r_q.num_vf),
        .route_ofs    (VF_OFFSET),
        .route_stride (VF_STRIDE),
        .dev_id       (VF_DEVID),
        .sup_pg       (sup_pg),
        .sys_pg       (r_q.sys_pg),
        .data         (rd_val)
    );

    always_comb begin
        r_d         = r_q;
        r_d.active  = act_d;
        r_d.act_cnt = cnt_d;
        if (wr_ctrl)  r_d.ctrl   = ctrl_m[FW-1:0];
        if (wr_numvf) r_d.num_vf = numvf_m[FW-1:0];
        if (wr_syspg) r_d.sys_pg = syspg_m[FW-1:0];
        if (cfg_rd)   r_d.rdata  = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.sys_pg <= PG_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_rdata     = r_q.rdata;
    assign vf_enabled    = r_q.active;
    assign vf_active_cnt = r_q.act_cnt;
endmodule

// File: rtl/sriov_cap_chk.sv
module sriov_cap_chk #(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned CAP_BASE = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic [15:0]       total_vfs,
    input logic              vf_enabled,
    input logic [15:0]       vf_active_cnt
);
    logic ctrl_hit;
    assign ctrl_hit = cfg_wr && (cfg_addr == ADDR_W'(CAP_BASE + 1)) && cfg_be[0];

    assert_cnt_within_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vf_enabled |-> (vf_active_cnt <= total_vfs));

    assert_idle_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vf_enabled |-> (vf_active_cnt == 16'd0));

    assert_rise_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vf_enabled) |-> $past(ctrl_hit && cfg_wdata[0]));

    assert_fall_needs_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vf_enabled) |-> $past(ctrl_hit && !cfg_wdata[0]));

    assert_count_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_enabled && $past(vf_enabled)) |-> $stable(vf_active_cnt));
endmodule

bind sriov_cap_regs sriov_cap_chk #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_addr      (cfg_addr),
    .cfg_be        (cfg_be),
    .cfg_wdata     (cfg_wdata),
    .total_vfs     (total_vfs),
    .vf_enabled    (vf_enabled),
    .vf_active_cnt (vf_active_cnt)
);

// File: tb/sriov_cap_regs_bench.sv
module sriov_cap_regs_bench;
    localparam int unsigned AW   = 10;
    localparam int unsigned BASE = 64;
    localparam logic [15:0] P_INIT = 16'd4, P_OFS = 16'd1, P_STR = 16'd2, P_DID = 16'h1235;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] total_vfs = 16'd8;
    logic [15:0] opt_pgsz = 16'h0;
    logic        vf_enabled;
    logic [15:0] vf_active_cnt;

    always #2.5 clk = ~clk;

    sriov_cap_regs #(.ADDR_W(AW), .CAP_BASE(BASE), .INIT_VFS(P_INIT),
                     .VF_OFFSET(P_OFS), .VF_STRIDE(P_STR), .VF_DEVID(P_DID)) u_sriov_cap_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .total_vfs(total_vfs),
        .opt_pgsz(opt_pgsz), .vf_enabled(vf_enabled), .vf_active_cnt(vf_active_cnt)
    );

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_ctrl = 0, m_numvf = 0, m_syspg = 16'h1, m_cnt = 0;
    logic        m_act = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge16(input logic [15:0] o, input logic [31:0] d,
                                            input logic [3:0] be, input logic [15:0] m);
        logic [15:0] r = o;
        if (be[0]) r[7:0]  = (o[7:0]  & ~m[7:0])  | (d[7:0]  & m[7:0]);
        if (be[1]) r[15:8] = (o[15:8] & ~m[15:8]) | (d[15:8] & m[15:8]);
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        if (a < BASE || a >= BASE + 16) return 32'h0;
        case (int'(a) - BASE)
            1: return {16'h0, m_ctrl};
            2: return {total_vfs, P_INIT};
            3: return {16'h0, m_numvf};
            4: return {P_STR, P_OFS};
            5: return {P_DID, 16'h0};
            6: return {16'h0, 16'h0553 | opt_pgsz};
            7: return {16'h0, m_syspg};
            default: return 32'h0;
        endcase
    endfunction

    task automatic wr(input string req, input logic [AW-1:0] a, input logic [3:0] be,
                      input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(posedge clk);
        if (a == BASE + 1) begin
            m_ctrl = merge16(m_ctrl, d, be, 16'h0019);
            if (be[0]) begin
                if (m_act) begin
                    if (!d[0]) begin m_act = 0; m_cnt = 0; end
                end else if (d[0] && m_numvf <= total_vfs) begin
                    m_act = 1; m_cnt = m_numvf;
                end
            end
        end
        if (a == BASE + 3) m_numvf = merge16(m_numvf, d, be, 16'hFFFF);
        if (a == BASE + 7) m_syspg = merge16(m_syspg, d, be, 16'h0553 | opt_pgsz);
        @(negedge clk);
        cfg_wr = 1'b0;
        check({req, " enabled"}, {31'h0, vf_enabled}, {31'h0, m_act});
        check({req, " count"}, {16'h0, vf_active_cnt}, {16'h0, m_cnt});
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a);
        logic [31:0] e;
        @(negedge clk);
        cfg_rd = 1'b1; cfg_addr = a;
        e = exp_read(a);
        @(negedge clk);
        cfg_rd = 1'b0;
        check(req, cfg_rdata, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20517));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        check("R1 enabled", {31'h0, vf_enabled}, 32'h0);
        check("R1 count", {16'h0, vf_active_cnt}, 32'h0);
        for (int i = 1; i < 8; i++) rd("R1 reset read", AW'(BASE + i));
        // R2 control mask (activates zero VFs: count 0 fits)
        wr("R2 ctrl all ones", AW'(BASE + 1), 4'hF, 32'hFFFF_FFFF);
        rd("R2 ctrl readback", AW'(BASE + 1));
        wr("R2 ctrl clear", AW'(BASE + 1), 4'hF, 32'h0);
        // R3 / R12 requested count and byte enables
        wr("R3 numvf", AW'(BASE + 3), 4'hF, 32'hFFFF_A5C3);
        rd("R3 numvf read", AW'(BASE + 3));
        wr("R12 numvf low byte", AW'(BASE + 3), 4'b0001, 32'h1234_56FF);
        rd("R12 numvf partial", AW'(BASE + 3));
        check("R12 value", {16'h0, m_numvf}, 32'h0000_A5FF);
        // R4 / R5 read-only fields
        for (int i = 2; i < 7; i++) begin
            if (i != 3) begin
                wr("R4 ro write", AW'(BASE + i), 4'hF, 32'hFFFF_FFFF);
                rd("R4 R5 ro read", AW'(BASE + i));
            end
        end
        // R6 system page size with mandatory mask
        wr("R6 syspg", AW'(BASE + 7), 4'hF, 32'h0000_FFFF);
        rd("R6 syspg read", AW'(BASE + 7));
        check("R6 value", {16'h0, m_syspg}, 32'h0000_0553);
        // R7 activation
        wr("R7 numvf 5", AW'(BASE + 3), 4'hF, 32'd5);
        wr("R7 enable", AW'(BASE + 1), 4'hF, 32'h1);
        check("R7 count is 5", {16'h0, vf_active_cnt}, 32'd5);
        // R9 re-enable keeps count, then disable
        wr("R9 numvf 7", AW'(BASE + 3), 4'hF, 32'd7);
        wr("R9 enable again", AW'(BASE + 1), 4'hF, 32'h19);
        check("R9 count held", {16'h0, vf_active_cnt}, 32'd5);
        wr("R9 disable", AW'(BASE + 1), 4'hF, 32'h18);
        // R8 over-limit request
        wr("R8 numvf 9", AW'(BASE + 3), 4'hF, 32'd9);
        wr("R8 enable", AW'(BASE + 1), 4'hF, 32'h1);
        check("R8 not enabled", {31'h0, vf_enabled}, 32'h0);
        rd("R8 ctrl bit kept", AW'(BASE + 1));
        // R7 boundary equal to total
        wr("R7 numvf 8", AW'(BASE + 3), 4'hF, 32'd8);
        wr("R7 enable at limit", AW'(BASE + 1), 4'hF, 32'h1);
        check("R7 count is 8", {16'h0, vf_active_cnt}, 32'd8);
        wr("R9 disable2", AW'(BASE + 1), 4'hF, 32'h0);
        // R10 control write without byte 0
        wr("R10 no be0", AW'(BASE + 1), 4'b1110, 32'hFFFF_FFFF);
        check("R10 stays off", {31'h0, vf_enabled}, 32'h0);
        // R11 out of window
        wr("R11 below", AW'(BASE - 1), 4'hF, 32'h1);
        wr("R11 above alias", AW'(BASE + 16 + 1), 4'hF, 32'h1);
        check("R11 stays off", {31'h0, vf_enabled}, 32'h0);
        rd("R11 read outside", AW'(BASE + 17));
        rd("R11 read outside low", AW'(BASE - 1));
        rd("R11 unmapped", AW'(BASE + 12));
        rd("R11 header dword", AW'(BASE));
        // R5 / R6 optional page sizes
        opt_pgsz = 16'h0AA0;
        rd("R5 sup read", AW'(BASE + 6));
        wr("R6 syspg opt", AW'(BASE + 7), 4'hF, 32'h0000_FFFF);
        check("R6 opt value", {16'h0, m_syspg}, 32'h0000_0FF3);
        // R13 read latency: rdata holds after strobe drops
        rd("R13 read", AW'(BASE + 2));
        @(negedge clk);
        check("R13 hold", cfg_rdata, {total_vfs, P_INIT});
        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [AW-1:0] a;
            logic [31:0]   d;
            a = AW'(BASE - 1 + ($urandom % 19));
            d = $urandom;
            if (a == BASE + 3) d = {d[31:16], 12'h0, 4'($urandom % 11)};
            wr("R7 R9 R12 random write", a, 4'($urandom), d);
            rd("R2 R6 R11 random read", a);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule